// File: doc/BRIEF.md
# Supply Shutdown Hold Sequencer

This block drives an active-low shutdown line for an external power supply. The line stays high, keeping the supply alive, while either of two control bits is set: a clock-generator enable bit and a supply-keep enable bit. Both bits are held inside the block. The register file updates them through separate write strobes, each with a data bit. When both bits fall to zero, the line does not drop at once. It stays high for a fixed hold interval of 2.93 ms, so that the host processor has time to finish its own orderly shutdown.

A sleep-entry strobe clears both enable bits, which starts the hold interval if the line was being kept high. A wake-up strobe raises the line again at any time and restarts the hold interval. If either enable bit is set again before the interval runs out, the countdown is abandoned and the line stays high. The hold length is given in clock ticks and is derived at elaboration time from the clock frequency parameter.

Top module: `psu_hold_seq`

## Requirements
- R1: While reset is asserted, `shutdown_n` is 1 and both `clkgen_en` and `keep_en` read 0.
- R2: A `keep_wr` with `keep_wdata`=1, and no `sleep_enter` in the same cycle, makes `keep_en` read 1 and `shutdown_n` read 1 from the next cycle.
- R3: A `clkgen_wr` with `clkgen_wdata`=1, and no `sleep_enter` in the same cycle, makes `clkgen_en` read 1 and `shutdown_n` read 1 from the next cycle.
- R4: In every cycle where `clkgen_en` or `keep_en` reads 1, `shutdown_n` is 1.
- R5: A keep edge is a clock edge that samples `wake_evt`=1, or after which an enable bit reads 1. The last edge of reset counts as a keep edge. `shutdown_n` goes low at exactly the HOLD_TICKS-th edge after the last keep edge, and it is 1 at all edges before that.
- R6: HOLD_TICKS is CLK_HZ × HOLD_NS / 10^9 rounded up. HOLD_NS defaults to 2,930,000 (2.93 ms), so CLK_HZ = 5000 gives 15.
- R7: `sleep_enter` clears both enable bits at the next edge. It overrides any write to either bit in the same cycle.
- R8: `wake_evt` makes `shutdown_n` read 1 from the next cycle and restarts the hold interval, even when both bits are 0.
- R9: Setting an enable bit again during the hold interval cancels the countdown, and `shutdown_n` stays 1.
- R10: Once `shutdown_n` is low, it stays low until a keep edge. Writes of 0 have no effect on it.
- R11: Each enable bit changes only on its own write strobe or on `sleep_enter`. A write to one bit leaves the other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkgen_wr | input | 1 | Write strobe for the clock-generator enable bit |
| clkgen_wdata | input | 1 | Value written to the clock-generator enable bit |
| keep_wr | input | 1 | Write strobe for the supply-keep enable bit |
| keep_wdata | input | 1 | Value written to the supply-keep enable bit |
| sleep_enter | input | 1 | One-cycle strobe: enter sleep, clear both bits |
| wake_evt | input | 1 | One-cycle strobe: a wake-up event occurred |
| shutdown_n | output | 1 | Active-low supply shutdown (1 = keep supply on) |
| clkgen_en | output | 1 | Current clock-generator enable bit |
| keep_en | output | 1 | Current supply-keep enable bit |

## Verification
The assertions assume that every input changes only between clock edges and is stable at each rising edge. They also assume that the strobes are plain levels sampled once per edge, so a strobe held high for several cycles counts as several events. The bench drives every input on the falling edge, and each step lasts exactly one cycle. It covers writes, sleep and wake one at a time and together in the same cycle, including a sleep that collides with a write. A short hold of 15 ticks, from a reduced clock parameter, lets the bench reach and check the full countdown and its cancellation many times.

// File: rtl/psh_pkg.sv
package psh_pkg;

  typedef struct packed {
    logic clkgen;
    logic keep;
  } en_bits_t;

  // Ticks of a clk_hz clock that cover hold_ns nanoseconds, rounded up.
  function automatic int hold_ticks(longint unsigned clk_hz, longint unsigned hold_ns);
    longint unsigned prod;
    longint unsigned ticks;
    prod  = clk_hz * hold_ns;
    ticks = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    return int'(ticks);
  endfunction

  // True when at least one enable bit holds the supply on.
  function automatic logic any_enabled(en_bits_t b);
    return b.clkgen | b.keep;
  endfunction

endpackage

// File: rtl/psh_enable_bits.sv
module psh_enable_bits
  import psh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clkgen_wr,
  input  logic     clkgen_wdata,
  input  logic     keep_wr,
  input  logic     keep_wdata,
  input  logic     sleep_enter,
  output en_bits_t bits_q,
  output en_bits_t bits_d
);

  always_comb begin
    bits_d = bits_q;
    if (clkgen_wr) bits_d.clkgen = clkgen_wdata;
    if (keep_wr)   bits_d.keep   = keep_wdata;
    if (sleep_enter) bits_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R7: sleep entry leaves both bits cleared
  a_r7_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> (bits_q == '0));

  // R11: without its own strobe or sleep, the clock-generator bit holds
  a_r11_clkgen_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkgen_wr && !sleep_enter) |=> $stable(bits_q.clkgen));

  // R11: without its own strobe or sleep, the keep bit holds
  a_r11_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_wr && !sleep_enter) |=> $stable(bits_q.keep));

endmodule

// File: rtl/psh_hold_timer.sv
module psh_hold_timer #(
  parameter int TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic keep,
  output logic active
);

  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] remain;
  logic          expired;

  assign expired = (remain == '0);
  assign active  = !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        remain <= LOAD;
    else if (keep)     remain <= LOAD;
    else if (!expired) remain <= remain - CW'(1);
  end

  // R5: the count steps down by one per edge when not reloaded
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep && !expired) |=> (remain == $past(remain) - CW'(1)));

  // R5: the line only falls from the final tick
  a_r5_fall_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(remain) == CW'(1)));

  // R10: an expired timer stays expired without a keep edge
  a_r10_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !keep) |=> expired);

endmodule

// File: rtl/psu_hold_seq.sv
module psu_hold_seq
  import psh_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 250_000_000,
  parameter longint unsigned HOLD_NS = 2_930_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clkgen_wr,
  input  logic clkgen_wdata,
  input  logic keep_wr,
  input  logic keep_wdata,
  input  logic sleep_enter,
  input  logic wake_evt,
  output logic shutdown_n,
  output logic clkgen_en,
  output logic keep_en
);

  localparam int HOLD_TICKS = hold_ticks(CLK_HZ, HOLD_NS);

  en_bits_t bits_q;
  en_bits_t bits_d;
  logic     keep_evt;
  logic     hold_active;

  psh_enable_bits u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .clkgen_wr    (clkgen_wr),
    .clkgen_wdata (clkgen_wdata),
    .keep_wr      (keep_wr),
    .keep_wdata   (keep_wdata),
    .sleep_enter  (sleep_enter),
    .bits_q       (bits_q),
    .bits_d       (bits_d)
  );

  // A keep edge: a bit will be set after this edge, or a wake-up arrives.
  assign keep_evt = any_enabled(bits_d) | wake_evt;

  psh_hold_timer #(.TICKS(HOLD_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .keep   (keep_evt),
    .active (hold_active)
  );

  assign shutdown_n = hold_active;
  assign clkgen_en  = bits_q.clkgen;
  assign keep_en    = bits_q.keep;

  // R2: a keep-bit write of one raises bit and line together
  a_r2_keep_write: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_wr && keep_wdata && !sleep_enter) |=> (keep_en && shutdown_n));

  // R3: a clock-generator write of one raises bit and line together
  a_r3_clkgen_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clkgen_wr && clkgen_wdata && !sleep_enter) |=> (clkgen_en && shutdown_n));

  // R4: an enabled bit always keeps the supply on
  a_r4_on_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (clkgen_en || keep_en) |-> shutdown_n);

  // R8: a wake-up raises the line on the next cycle
  a_r8_wake_raises: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> shutdown_n);

endmodule

// File: tb/psu_hold_seq_test.sv
`timescale 1ns/1ps
module psu_hold_seq_test;

  localparam longint unsigned TB_CLK_HZ = 5000;
  // R6: restated as whole hundredths of a millisecond, rounded up
  localparam int HOLD = (5000 * 293 + 99_999) / 100_000;

  typedef struct {
    logic  out;
    logic  cg;
    logic  kp;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clkgen_wr = 1'b0, clkgen_wdata = 1'b0;
  logic keep_wr = 1'b0, keep_wdata = 1'b0;
  logic sleep_enter = 1'b0, wake_evt = 1'b0;
  logic shutdown_n, clkgen_en, keep_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  exp_t q[$];

  logic m_cg = 1'b0, m_kp = 1'b0;
  int   since = 0;

  always #2 clk = ~clk;

  psu_hold_seq #(.CLK_HZ(TB_CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n),
    .clkgen_wr(clkgen_wr), .clkgen_wdata(clkgen_wdata),
    .keep_wr(keep_wr), .keep_wdata(keep_wdata),
    .sleep_enter(sleep_enter), .wake_evt(wake_evt),
    .shutdown_n(shutdown_n), .clkgen_en(clkgen_en), .keep_en(keep_en)
  );

  // Driver: called at a falling edge; applies one cycle of stimulus.
  task automatic step(input logic cw, input logic cd, input logic kw, input logic kd,
                      input logic sl, input logic wk, input string tag);
    exp_t e;
    clkgen_wr = cw; clkgen_wdata = cd;
    keep_wr = kw;   keep_wdata = kd;
    sleep_enter = sl; wake_evt = wk;
    if (sl) begin
      m_cg = 1'b0; m_kp = 1'b0;
    end else begin
      if (cw) m_cg = cd;
      if (kw) m_kp = kd;
    end
    if (m_cg || m_kp || wk) since = 0;
    else if (since < HOLD) since = since + 1;
    e.out = (since < HOLD);
    e.cg = m_cg; e.kp = m_kp; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares each expected item just after its edge.
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (shutdown_n !== e.out || clkgen_en !== e.cg || keep_en !== e.kp) begin
        n_bad++;
        $display("FAIL %s: got out=%0b clkgen=%0b keep=%0b expected out=%0b clkgen=%0b keep=%0b",
                 e.tag, shutdown_n, clkgen_en, keep_en, e.out, e.cg, e.kp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (shutdown_n !== 1'b1 || clkgen_en !== 1'b0 || keep_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got out=%0b clkgen=%0b keep=%0b expected out=1 clkgen=0 keep=0",
               shutdown_n, clkgen_en, keep_en);
    end
    rst_n = 1'b1;
    idle(HOLD + 4, "R5 R6 hold after reset");
    step(0, 0, 1, 1, 0, 0, "R2 keep write one");
    idle(5, "R4 on while keep set");
    step(0, 0, 1, 0, 0, 0, "R5 keep cleared");
    idle(HOLD + 3, "R5 countdown after clear");
    step(1, 1, 0, 0, 0, 0, "R3 clkgen write one");
    idle(3, "R4 on while clkgen set");
    step(1, 0, 0, 0, 0, 0, "R5 clkgen cleared");
    idle(8, "R5 partial hold");
    step(1, 1, 0, 0, 0, 0, "R9 re-enable during hold");
    idle(HOLD + 2, "R9 stays on");
    step(1, 0, 0, 0, 0, 0, "R5 clkgen cleared again");
    idle(HOLD + 2, "R5 second countdown");
    step(1, 0, 1, 0, 0, 0, "R10 zero writes while low");
    idle(3, "R10 still low");
    step(0, 0, 0, 0, 0, 1, "R8 wake while low");
    idle(6, "R8 hold after wake");
    step(0, 0, 0, 0, 0, 1, "R8 wake restarts hold");
    idle(HOLD + 2, "R8 countdown after wake");
    step(1, 1, 1, 1, 0, 0, "R2 R3 both set");
    idle(2, "R4 both set");
    step(0, 0, 1, 1, 1, 0, "R7 sleep beats write");
    idle(HOLD + 2, "R7 hold after sleep");
    step(1, 1, 0, 0, 0, 0, "R11 clkgen set");
    step(0, 0, 1, 0, 0, 0, "R11 keep write leaves clkgen");
    step(0, 0, 1, 1, 0, 0, "R11 keep set");
    step(1, 0, 0, 0, 0, 0, "R11 clkgen write leaves keep");
    idle(2, "R4 keep alone");
    step(0, 0, 0, 0, 1, 1, "R7 R8 sleep with wake");
    idle(HOLD + 2, "R8 countdown after sleep wake");
    step(0, 0, 0, 0, 1, 0, "R10 sleep while low");
    idle(2, "R10 low after sleep");
    @(posedge clk); #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule